// File: doc/BRIEF.md
# Batch Anti-Starvation Age Tracker

This block sits beside the bank arbiter of a DRAM channel controller and keeps a slow request from waiting forever behind a steady stream of requests that suit the data bus better. It groups pending work into batches. When no batch is open, every bank that has a nonempty request queue is marked as a member of a new batch. An age counter then measures how long the batch has been open.

Each bank that issues leaves the batch. If the batch is still open after more than twice the bank busy time, the tracker raises a hold-off. While hold-off is high, the eligibility mask it gives the arbiter lets only batch members issue, until the batch drains.

Inputs are a per-bank queue-nonempty vector and a per-bank issue pulse from the arbiter. All outputs are registered. They describe the state the arbiter must honour in the current cycle.

Top module: `batch_age_tracker`

## Requirements
- R1: After reset, `old_flags` is all zeros, `hold_off` is 0 and `issue_eligible` is all ones.
- R2: At a clock edge where no flag remains set once that cycle's `issue_pulse` is applied, `old_flags` becomes a copy of `queue_nonempty` sampled at that edge, and the age count restarts at zero.
- R3: A bank whose flag is set and whose `issue_pulse` bit is high has its flag cleared at the next edge, unless R2 forms a new batch at that edge.
- R4: The age count rises by one per clock while a batch stays open. `hold_off` goes high at the edge that ends the (2*BUSY_TIME+1)-th cycle after batch formation, provided the batch is still open then.
- R5: While `hold_off` is 1, `issue_eligible` equals `old_flags`. While `hold_off` is 0, `issue_eligible` is all ones (bit i belongs to bank i).
- R6: The age count saturates instead of wrapping. Once high, `hold_off` stays high for as long as the batch stays open, however long that is.
- R7: When the last flag of a batch clears, `hold_off` drops at that edge and a new batch is formed from `queue_nonempty`.
- R8: An `issue_pulse` bit for a bank whose flag is clear changes no flag and does not change the age progression.
- R9: A bank whose queue becomes nonempty while a batch is open does not join that batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| queue_nonempty | input | N_BANKS | Bank i has at least one queued request |
| issue_pulse | input | N_BANKS | Bank i issues a request this cycle |
| old_flags | output | N_BANKS | Bank i belongs to the open batch |
| hold_off | output | 1 | Batch overdue; only members may issue |
| issue_eligible | output | N_BANKS | Bank i may issue this cycle |

## Verification
A wrong age count shows as `hold_off` rising one or more cycles too early or too late relative to batch formation. A wrapping counter shows as `hold_off` falling while members are still pending. A lost or stale flag shows on `old_flags` at the very next edge. It also shows as a bank wrongly masked in `issue_eligible` once hold-off is active. The bench walks a batch from formation past the threshold and deep into saturation, then drains it, and compares every output against a reference model after every edge.

// File: rtl/batch_age_pkg.sv
package batch_age_pkg;

  // Largest value the age counter holds: one past the hold threshold.
  function automatic int age_ceiling(input int busy_time);
    return 2 * busy_time + 1;
  endfunction

  // Counter width able to hold the ceiling value.
  function automatic int age_width(input int busy_time);
    return $clog2(2 * busy_time + 2);
  endfunction

endpackage

// File: rtl/batch_flag_bank.sv
module batch_flag_bank #(
  parameter int N_BANKS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_BANKS-1:0] queue_nonempty,
  input  logic [N_BANKS-1:0] issue_pulse,
  output logic [N_BANKS-1:0] flags_q,
  output logic [N_BANKS-1:0] flags_d,
  output logic               batch_done
);

  logic [N_BANKS-1:0] remaining;

  assign remaining  = flags_q & ~issue_pulse;
  assign batch_done = (remaining == '0);

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    always_comb begin
      if (batch_done) flags_d[b] = queue_nonempty[b];
      else            flags_d[b] = remaining[b];
    end

    always_ff @(posedge clk) begin
      if (rst) flags_q[b] <= 1'b0;
      else     flags_q[b] <= flags_d[b];
    end
  end

endmodule

// File: rtl/batch_age_counter.sv
module batch_age_counter
  import batch_age_pkg::*;
#(
  parameter int BUSY_TIME = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic overdue_d
);

  localparam int AGE_W   = age_width(BUSY_TIME);
  localparam int AGE_TOP = age_ceiling(BUSY_TIME);
  localparam int THRESH  = 2 * BUSY_TIME;

  logic [AGE_W-1:0] age_q;
  logic [AGE_W-1:0] age_d;

  always_comb begin
    if (restart)                         age_d = '0;
    else if (age_q >= AGE_W'(AGE_TOP))   age_d = AGE_W'(AGE_TOP);
    else                                 age_d = age_q + AGE_W'(1);
  end

  assign overdue_d = (age_d > AGE_W'(THRESH));

  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else     age_q <= age_d;
  end

endmodule

// File: rtl/batch_mask_reg.sv
module batch_mask_reg #(
  parameter int N_BANKS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               overdue_d,
  input  logic [N_BANKS-1:0] flags_d,
  output logic               hold_q,
  output logic [N_BANKS-1:0] eligible_q
);

  logic [N_BANKS-1:0] eligible_d;

  assign eligible_d = overdue_d ? flags_d : {N_BANKS{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= 1'b0;
      eligible_q <= {N_BANKS{1'b1}};
    end else begin
      hold_q     <= overdue_d;
      eligible_q <= eligible_d;
    end
  end

endmodule

// File: rtl/batch_age_tracker.sv
module batch_age_tracker #(
  parameter int N_BANKS   = 8,
  parameter int BUSY_TIME = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_BANKS-1:0] queue_nonempty,
  input  logic [N_BANKS-1:0] issue_pulse,
  output logic [N_BANKS-1:0] old_flags,
  output logic               hold_off,
  output logic [N_BANKS-1:0] issue_eligible
);

  logic [N_BANKS-1:0] flags_next;
  logic               batch_done;
  logic               overdue_next;

  batch_flag_bank #(.N_BANKS(N_BANKS)) u_flags (
    .clk            (clk),
    .rst            (rst),
    .queue_nonempty (queue_nonempty),
    .issue_pulse    (issue_pulse),
    .flags_q        (old_flags),
    .flags_d        (flags_next),
    .batch_done     (batch_done)
  );

  batch_age_counter #(.BUSY_TIME(BUSY_TIME)) u_age (
    .clk       (clk),
    .rst       (rst),
    .restart   (batch_done),
    .overdue_d (overdue_next)
  );

  batch_mask_reg #(.N_BANKS(N_BANKS)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .overdue_d  (overdue_next),
    .flags_d    (flags_next),
    .hold_q     (hold_off),
    .eligible_q (issue_eligible)
  );

endmodule

// File: rtl/batch_age_tracker_chk.sv
module batch_age_tracker_chk #(
  parameter int N_BANKS   = 8,
  parameter int BUSY_TIME = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [N_BANKS-1:0] queue_nonempty,
  input logic [N_BANKS-1:0] issue_pulse,
  input logic [N_BANKS-1:0] old_flags,
  input logic               hold_off,
  input logic [N_BANKS-1:0] issue_eligible
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (old_flags == '0 && !hold_off && issue_eligible == {N_BANKS{1'b1}}));

  p_form_batch_r2: assert property (@(posedge clk) disable iff (rst)
    ((old_flags & ~issue_pulse) == '0) |=> (old_flags == $past(queue_nonempty) && !hold_off));

  p_issue_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (|(old_flags & ~issue_pulse)) |=> ((old_flags & $past(old_flags & issue_pulse)) == '0));

  p_no_joiners_r9: assert property (@(posedge clk) disable iff (rst)
    (|(old_flags & ~issue_pulse)) |=> ((old_flags & ~$past(old_flags)) == '0));

  p_mask_follows_r5: assert property (@(posedge clk) disable iff (rst)
    hold_off |-> (issue_eligible == old_flags));

  p_open_mask_r5: assert property (@(posedge clk) disable iff (rst)
    !hold_off |-> (issue_eligible == {N_BANKS{1'b1}}));

  p_hold_persists_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_off && |(old_flags & ~issue_pulse)) |=> hold_off);

  p_hold_needs_batch_r4: assert property (@(posedge clk) disable iff (rst)
    hold_off |-> (old_flags != '0));

endmodule

bind batch_age_tracker batch_age_tracker_chk #(
  .N_BANKS   (N_BANKS),
  .BUSY_TIME (BUSY_TIME)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .queue_nonempty (queue_nonempty),
  .issue_pulse    (issue_pulse),
  .old_flags      (old_flags),
  .hold_off       (hold_off),
  .issue_eligible (issue_eligible)
);

// File: tb/test_batch_age_tracker.sv
module test_batch_age_tracker;

  localparam int NB    = 4;
  localparam int BUSY  = 3;
  localparam int LIMIT = 2 * BUSY;
  localparam int TOP   = 2 * BUSY + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] queue_nonempty = '0;
  logic [NB-1:0] issue_pulse = '0;
  logic [NB-1:0] old_flags;
  logic          hold_off;
  logic [NB-1:0] issue_eligible;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [NB-1:0] old;
    logic          hold;
    logic [NB-1:0] elig;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  logic [NB-1:0] m_old = '0;
  int            m_age = 0;

  always #5 clk = ~clk;

  batch_age_tracker #(.N_BANKS(NB), .BUSY_TIME(BUSY)) i_batch_age_tracker (
    .clk            (clk),
    .rst            (rst),
    .queue_nonempty (queue_nonempty),
    .issue_pulse    (issue_pulse),
    .old_flags      (old_flags),
    .hold_off       (hold_off),
    .issue_eligible (issue_eligible)
  );

  task automatic compare(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the model's expectation.
  task automatic step(input logic [NB-1:0] ne, input logic [NB-1:0] iss, input string tag);
    exp_t e;
    logic [NB-1:0] left;
    @(negedge clk);
    queue_nonempty = ne;
    issue_pulse    = iss;
    left = m_old & ~iss;
    if (left == '0) begin
      m_old = ne;
      m_age = 0;
    end else begin
      m_old = left;
      m_age = (m_age >= TOP) ? TOP : m_age + 1;
    end
    e.old  = m_old;
    e.hold = (m_age > LIMIT);
    e.elig = e.hold ? m_old : {NB{1'b1}};
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: after each edge, pops the expectation and compares.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compare(e.tag, "old_flags", int'(old_flags), int'(e.old));
      compare(e.tag, "hold_off", int'(hold_off), int'(e.hold));
      compare(e.tag, "issue_eligible", int'(issue_eligible), int'(e.elig));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    compare("R1", "old_flags", int'(old_flags), 0);
    compare("R1", "hold_off", int'(hold_off), 0);
    compare("R1", "issue_eligible", int'(issue_eligible), 4'hF);
    @(negedge clk);
    rst = 1'b0;

    step(4'b0000, 4'b0000, "R2");          // nothing queued: empty batch
    step(4'b1011, 4'b0000, "R2");          // batch formed from queues
    step(4'b1111, 4'b0001, "R3");          // bank 0 issues, bank 2 arrives
    step(4'b1111, 4'b0100, "R8");          // non-member issue pulse ignored
    for (int k = 0; k < 4; k++) step(4'b1111, 4'b0000, "R4");  // age 3..6, no hold
    step(4'b1111, 4'b0000, "R5");          // age 7: hold, mask = flags
    for (int k = 0; k < 10; k++) step(4'b1111, 4'b0000, "R6"); // saturated, hold kept
    step(4'b1111, 4'b0010, "R9");          // member leaves, bank 2 still outside
    step(4'b0110, 4'b1000, "R7");          // last member leaves: new batch
    step(4'b0110, 4'b0000, "R4");
    step(4'b0110, 4'b0110, "R7");          // drains immediately, forms again
    step(4'b0000, 4'b0000, "R2");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule